// File: doc/BRIEF.md
# Ethernet PHY Mode Control Register with Latching Status Bits

This block holds the 16-bit mode control word of an Ethernet PHY behind a 32-bit register bus. Management software writes it to select loopback, power-down and port isolation, to choose speed and duplex by hand, or to hand those choices to auto-negotiation. Two command bits clear themselves on handshakes from the PHY core. The soft-reset command sends a one-cycle reset pulse to the core and stays visible until the core reports completion. The negotiation-restart command stays pending until the negotiation engine reports that it has started.

The block drives the effective speed and duplex seen by the rest of the PHY. When auto-negotiation is on, these come from the negotiated result inputs; when it is off, they come from the manual bits.

A second address holds a status word built from generic latching cells. Latched-high cells record that an event happened. Latched-low cells record that a condition dropped. A status read clears both kinds, but an event that arrives in the same cycle as the read is kept.

Top module: `phy_ctl_reg`

## Requirements
- R1: Read data bits 31:16 are always zero. Control-word bits 7:0 are reserved: writes to them are ignored and they read as zero.
- R2: While `rst_n` is low, the control word resets as follows: bit 13 takes `strap_spd100`, bit 12 takes `strap_an_en`, bit 8 takes `strap_fdx`, and every other bit is 0. Every latched-high cell resets to 0 and every latched-low cell resets to 1.
- R3: A control write (`bus_addr`=0) with bit 15 set does three things. It returns the control word to the strap defaults of R2 and resets the status cells. It sets bit 15. It drives `core_rst_pulse` high for exactly the following cycle. Bit 15 then reads 1 until a cycle with `core_rst_done` high, after which it reads 0. Control writes are ignored while bit 15 reads 1.
- R4: When bit 12 (auto-negotiation enable) is 1, `eff_spd100` and `eff_fdx` follow `an_res_spd100` and `an_res_fdx`. When bit 12 is 0, they follow bit 13 (1 = 100 Mb/s) and bit 8 (1 = full duplex).
- R5: A control write with bits 9 and 12 both set makes bit 9 (the restart request, also driven on `an_restart_req`) read 1. It stays 1 until a cycle with `an_started` high, after which it reads 0. A later write with bit 9 at 0 does not clear a pending request.
- R6: A control write with bit 9 set and bit 12 clear does not raise a restart request.
- R7: Bits 14 (loopback), 11 (power-down) and 10 (isolate) are plain read/write bits. They drive `lpbk_en`, `pwr_down` and `iso_en`.
- R8: A latched-high cell goes to 1 in the cycle after its event and holds until a status read. After the read it returns to 0, unless an event occurred in the read cycle, in which case it stays 1.
- R9: A latched-low cell goes to 0 in the cycle after its event and holds until a status read. After the read it returns to 1, unless an event occurred in the read cycle, in which case it stays 0.
- R10: A read with `bus_addr`=1 returns the status word. Latched-high cell i sits at bit i, and latched-low cell j sits at bit NUM_LH+j; all other bits are zero. Writes to address 1 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hard reset |
| strap_an_en | input | 1 | Strap default for auto-negotiation enable |
| strap_spd100 | input | 1 | Strap default for speed bit |
| strap_fdx | input | 1 | Strap default for duplex bit |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (clears status on address 1) |
| bus_addr | input | 1 | 0 = control word, 1 = status word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word |
| core_rst_done | input | 1 | PHY core reports that the soft reset has finished |
| an_started | input | 1 | Negotiation engine reports that a restart has begun |
| an_res_spd100 | input | 1 | Negotiated speed, 1 = 100 Mb/s |
| an_res_fdx | input | 1 | Negotiated duplex, 1 = full |
| lh_evt | input | NUM_LH | Events for the latched-high cells |
| ll_evt | input | NUM_LL | Events for the latched-low cells |
| core_rst_pulse | output | 1 | One-cycle reset pulse to the PHY core |
| an_restart_req | output | 1 | Pending negotiation restart |
| lpbk_en | output | 1 | Loopback enable |
| pwr_down | output | 1 | Power-down request |
| iso_en | output | 1 | Isolate the port from the MII |
| eff_spd100 | output | 1 | Effective speed, 1 = 100 Mb/s |
| eff_fdx | output | 1 | Effective duplex, 1 = full |

## Verification
Random control writes set bit 12 both ways while the negotiated result inputs toggle on their own. This separates the auto-negotiated speed and duplex path from the manual path. Restart writes are mixed with writes that clear bit 9, and `an_started` arrives at random. This distinguishes a request that holds, one that is wrongly dropped by a write, and one wrongly raised while negotiation is disabled. Sparse random status events collide with status reads in the same cycle, which shows whether a read swallows a fresh event. Directed runs add strap-driven hard-reset values, reserved-bit writes, and a soft reset with writes issued while it is still in progress.

// File: rtl/phy_ctl_pkg.sv
package phy_ctl_pkg;
  typedef enum logic [0:0] {STS_LATCH_HI = 1'b0, STS_LATCH_LO = 1'b1} sts_kind_e;

  localparam int CW = 16;
  localparam int B_SRST = 15;
  localparam int B_LPBK = 14;
  localparam int B_SPD  = 13;
  localparam int B_ANEN = 12;
  localparam int B_PDN  = 11;
  localparam int B_ISO  = 10;
  localparam int B_RSAN = 9;
  localparam int B_FDX  = 8;

  // effective mode: negotiated value wins when negotiation is enabled
  function automatic logic mode_pick(input logic an_en, input logic negotiated,
                                     input logic manual);
    return an_en ? negotiated : manual;
  endfunction

  // strap-derived default control word
  function automatic logic [CW-1:0] ctrl_default(input logic an_en, input logic spd,
                                                 input logic fdx);
    logic [CW-1:0] w;
    w = '0;
    w[B_SPD]  = spd;
    w[B_ANEN] = an_en;
    w[B_FDX]  = fdx;
    return w;
  endfunction
endpackage

// File: rtl/phy_sts_latch.sv
module phy_sts_latch
  import phy_ctl_pkg::*;
#(
  parameter sts_kind_e KIND = STS_LATCH_HI
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic evt,
  input  logic rd,
  output logic q
);
  localparam logic ACTIVE = (KIND == STS_LATCH_HI);
  localparam logic IDLE   = ~ACTIVE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= IDLE;
    else if (clr)  q <= IDLE;
    else if (evt)  q <= ACTIVE;
    else if (rd)   q <= IDLE;
  end

  // R8 (latched-high) and R9 (latched-low): an event is never lost to a read
  p_evt_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !clr) |=> (q == ACTIVE));
endmodule

// File: rtl/phy_sts_bank.sv
module phy_sts_bank
  import phy_ctl_pkg::*;
#(
  parameter int NUM_LH = 4,
  parameter int NUM_LL = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              rd,
  input  logic [NUM_LH-1:0] lh_evt,
  input  logic [NUM_LL-1:0] ll_evt,
  output logic [CW-1:0]     word
);
  localparam int USED = NUM_LH + NUM_LL;

  logic [NUM_LH-1:0] lh_q;
  logic [NUM_LL-1:0] ll_q;

  for (genvar i = 0; i < NUM_LH; i++) begin : g_lh
    phy_sts_latch #(.KIND(STS_LATCH_HI)) u_cell (
      .clk(clk), .rst_n(rst_n), .clr(clr), .evt(lh_evt[i]), .rd(rd), .q(lh_q[i]));
  end

  for (genvar j = 0; j < NUM_LL; j++) begin : g_ll
    phy_sts_latch #(.KIND(STS_LATCH_LO)) u_cell (
      .clk(clk), .rst_n(rst_n), .clr(clr), .evt(ll_evt[j]), .rd(rd), .q(ll_q[j]));
  end

  if (USED < CW) begin : g_pad
    assign word = {{(CW-USED){1'b0}}, ll_q, lh_q};
  end else begin : g_full
    assign word = {ll_q, lh_q};
  end
endmodule

// File: rtl/phy_mode_resolve.sv
module phy_mode_resolve
  import phy_ctl_pkg::*;
(
  input  logic an_en,
  input  logic man_spd,
  input  logic man_fdx,
  input  logic neg_spd,
  input  logic neg_fdx,
  output logic eff_spd,
  output logic eff_fdx
);
  assign eff_spd = mode_pick(an_en, neg_spd, man_spd);
  assign eff_fdx = mode_pick(an_en, neg_fdx, man_fdx);
endmodule

// File: rtl/phy_ctl_reg.sv
module phy_ctl_reg
  import phy_ctl_pkg::*;
#(
  parameter int NUM_LH = 4,
  parameter int NUM_LL = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_an_en,
  input  logic              strap_spd100,
  input  logic              strap_fdx,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              core_rst_done,
  input  logic              an_started,
  input  logic              an_res_spd100,
  input  logic              an_res_fdx,
  input  logic [NUM_LH-1:0] lh_evt,
  input  logic [NUM_LL-1:0] ll_evt,
  output logic              core_rst_pulse,
  output logic              an_restart_req,
  output logic              lpbk_en,
  output logic              pwr_down,
  output logic              iso_en,
  output logic              eff_spd100,
  output logic              eff_fdx
);
  logic [CW-1:0] dflt;
  logic [CW-1:0] ctl_word;
  logic [CW-1:0] sts_word;
  logic          r_lpbk, r_spd, r_anen, r_pdn, r_iso, r_fdx;
  logic          rst_busy, an_pend, pulse_q;

  // named internal events
  logic wr_ctl, soft_rst_go, an_set_go, sts_rd;
  logic unused_wbits;

  assign dflt        = ctrl_default(strap_an_en, strap_spd100, strap_fdx);
  assign wr_ctl      = bus_wr && !bus_addr && !rst_busy;
  assign soft_rst_go = wr_ctl && bus_wdata[B_SRST];
  assign an_set_go   = wr_ctl && !bus_wdata[B_SRST] && bus_wdata[B_RSAN] && bus_wdata[B_ANEN];
  assign sts_rd      = bus_rd && bus_addr;
  assign unused_wbits = ^{bus_wdata[31:16], bus_wdata[7:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_lpbk   <= 1'b0;
      r_spd    <= strap_spd100;
      r_anen   <= strap_an_en;
      r_pdn    <= 1'b0;
      r_iso    <= 1'b0;
      r_fdx    <= strap_fdx;
      rst_busy <= 1'b0;
      an_pend  <= 1'b0;
      pulse_q  <= 1'b0;
    end else begin
      pulse_q <= soft_rst_go;
      if (soft_rst_go) begin
        r_lpbk   <= dflt[B_LPBK];
        r_spd    <= dflt[B_SPD];
        r_anen   <= dflt[B_ANEN];
        r_pdn    <= dflt[B_PDN];
        r_iso    <= dflt[B_ISO];
        r_fdx    <= dflt[B_FDX];
        rst_busy <= 1'b1;
        an_pend  <= 1'b0;
      end else begin
        if (rst_busy && core_rst_done) rst_busy <= 1'b0;
        if (wr_ctl) begin
          r_lpbk <= bus_wdata[B_LPBK];
          r_spd  <= bus_wdata[B_SPD];
          r_anen <= bus_wdata[B_ANEN];
          r_pdn  <= bus_wdata[B_PDN];
          r_iso  <= bus_wdata[B_ISO];
          r_fdx  <= bus_wdata[B_FDX];
        end
        if (an_set_go)       an_pend <= 1'b1;
        else if (an_started) an_pend <= 1'b0;
      end
    end
  end

  always_comb begin
    ctl_word         = '0;
    ctl_word[B_SRST] = rst_busy;
    ctl_word[B_LPBK] = r_lpbk;
    ctl_word[B_SPD]  = r_spd;
    ctl_word[B_ANEN] = r_anen;
    ctl_word[B_PDN]  = r_pdn;
    ctl_word[B_ISO]  = r_iso;
    ctl_word[B_RSAN] = an_pend;
    ctl_word[B_FDX]  = r_fdx;
  end

  phy_sts_bank #(.NUM_LH(NUM_LH), .NUM_LL(NUM_LL)) u_sts (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst_go), .rd(sts_rd),
    .lh_evt(lh_evt), .ll_evt(ll_evt), .word(sts_word));

  phy_mode_resolve u_mode (
    .an_en(r_anen), .man_spd(r_spd), .man_fdx(r_fdx),
    .neg_spd(an_res_spd100), .neg_fdx(an_res_fdx),
    .eff_spd(eff_spd100), .eff_fdx(eff_fdx));

  assign bus_rdata      = {16'h0000, bus_addr ? sts_word : ctl_word};
  assign core_rst_pulse = pulse_q;
  assign an_restart_req = an_pend;
  assign lpbk_en        = r_lpbk;
  assign pwr_down       = r_pdn;
  assign iso_en         = r_iso;

  // R3: reset pulse lasts one cycle
  p_pulse_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst_pulse |=> !core_rst_pulse);
  // R3: soft reset stays in progress until the core reports done
  p_busy_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_busy && !core_rst_done) |=> rst_busy);
  // R5: pending restart survives anything but the start handshake or a soft reset
  p_restart_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (an_restart_req && !an_started && !soft_rst_go) |=> an_restart_req);
  // R6: restart write with negotiation disabled raises nothing
  p_restart_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && bus_wdata[B_RSAN] && !bus_wdata[B_ANEN] && !an_restart_req) |=> !an_restart_req);
endmodule

// File: tb/test_phy_ctl_reg.sv
module test_phy_ctl_reg;
  localparam int CLK_PERIOD = 10;
  localparam int NLH = 4;
  localparam int NLL = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_an = 1'b1, s_spd = 1'b1, s_fdx = 1'b0;
  logic wr = 0, rd = 0, addr = 0;
  logic [31:0] wd = '0;
  logic [31:0] rdat;
  logic done_i = 0, started = 0, n_spd = 0, n_fdx = 0;
  logic [NLH-1:0] lh = '0;
  logic [NLL-1:0] ll = '0;
  logic pulse, req, lpbk, pdn, iso, e_spd, e_fdx;

  int checks = 0, fails = 0;
  bit finished = 0;

  // bench model
  logic [15:0] m_ctl;
  logic m_pulse;
  logic [NLH-1:0] m_lh;
  logic [NLL-1:0] m_ll;

  always #(CLK_PERIOD/2) clk = ~clk;

  phy_ctl_reg #(.NUM_LH(NLH), .NUM_LL(NLL)) i_phy_ctl_reg (
    .clk(clk), .rst_n(rst_n), .strap_an_en(s_an), .strap_spd100(s_spd), .strap_fdx(s_fdx),
    .bus_wr(wr), .bus_rd(rd), .bus_addr(addr), .bus_wdata(wd), .bus_rdata(rdat),
    .core_rst_done(done_i), .an_started(started), .an_res_spd100(n_spd), .an_res_fdx(n_fdx),
    .lh_evt(lh), .ll_evt(ll), .core_rst_pulse(pulse), .an_restart_req(req),
    .lpbk_en(lpbk), .pwr_down(pdn), .iso_en(iso), .eff_spd100(e_spd), .eff_fdx(e_fdx));

  function automatic logic [15:0] strap_word(logic a, logic s, logic f);
    logic [15:0] w = 16'h0000;
    if (s) w = w | 16'h2000;
    if (a) w = w | 16'h1000;
    if (f) w = w | 16'h0100;
    return w;
  endfunction

  function automatic logic pick_eff(logic an, logic neg, logic man);
    if (an == 1'b1) return neg;
    return man;
  endfunction

  task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_ctl = strap_word(s_an, s_spd, s_fdx);
    m_pulse = 0;
    m_lh = '0;
    m_ll = '1;
  endtask

  // compare all outputs with the model for the current inputs
  task automatic compare();
    logic [31:0] exp_rd;
    exp_rd = addr ? {16'h0, {(16-NLH-NLL){1'b0}}, m_ll, m_lh} : {16'h0, m_ctl};
    if (addr) check(rdat === exp_rd, "R8 R9 R10 status read", rdat, exp_rd);
    else      check(rdat === exp_rd, "R1 R3 R5 R6 R7 control read", rdat, exp_rd);
    check(pulse === m_pulse, "R3 core_rst_pulse", {31'h0, pulse}, {31'h0, m_pulse});
    check(req === m_ctl[9], "R5 R6 an_restart_req", {31'h0, req}, {31'h0, m_ctl[9]});
    check({lpbk, pdn, iso} === {m_ctl[14], m_ctl[11], m_ctl[10]}, "R7 mode outputs",
          {29'h0, lpbk, pdn, iso}, {29'h0, m_ctl[14], m_ctl[11], m_ctl[10]});
    check(e_spd === pick_eff(m_ctl[12], n_spd, m_ctl[13]), "R4 eff_spd100",
          {31'h0, e_spd}, {31'h0, pick_eff(m_ctl[12], n_spd, m_ctl[13])});
    check(e_fdx === pick_eff(m_ctl[12], n_fdx, m_ctl[8]), "R4 eff_fdx",
          {31'h0, e_fdx}, {31'h0, pick_eff(m_ctl[12], n_fdx, m_ctl[8])});
  endtask

  // advance model as the coming clock edge will
  task automatic model_step();
    bit busy, wctl, go;
    busy = m_ctl[15];
    wctl = wr && !addr && !busy;
    go = wctl && wd[15];
    m_pulse = go;
    if (go) begin
      m_ctl = strap_word(s_an, s_spd, s_fdx) | 16'h8000;
      m_lh = '0;
      m_ll = '1;
    end else begin
      if (busy && done_i) m_ctl[15] = 1'b0;
      if (wctl) begin
        m_ctl[14] = wd[14]; m_ctl[13] = wd[13]; m_ctl[12] = wd[12];
        m_ctl[11] = wd[11]; m_ctl[10] = wd[10]; m_ctl[8] = wd[8];
      end
      if (wctl && wd[9] && wd[12]) m_ctl[9] = 1'b1;
      else if (started)            m_ctl[9] = 1'b0;
      for (int i = 0; i < NLH; i++)
        if (lh[i]) m_lh[i] = 1'b1; else if (rd && addr) m_lh[i] = 1'b0;
      for (int j = 0; j < NLL; j++)
        if (ll[j]) m_ll[j] = 1'b0; else if (rd && addr) m_ll[j] = 1'b1;
    end
  endtask

  // inputs already set at a negedge: settle, compare, then clock
  task automatic cycle();
    #1;
    compare();
    model_step();
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    wr = 0; rd = 0; addr = 0; wd = '0; done_i = 0; started = 0; lh = '0; ll = '0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'd24681));
    // R2: hard reset with straps an=1 spd=1 fdx=0
    repeat (3) @(negedge clk);
    #1;
    check(rdat === 32'h0000_3000, "R2 reset control word", rdat, 32'h0000_3000);
    addr = 1; #1;
    check(rdat === 32'h0000_00F0, "R2 reset status word", rdat, 32'h0000_00F0);
    addr = 0;
    rst_n = 1;
    model_reset();
    @(negedge clk);

    // R1: reserved and upper bits ignored; manual mode, no restart (R6)
    idle_inputs(); wr = 1; wd = 32'hFFFF_6FFF & ~32'h0000_9000 | 32'h0000_0200; cycle();
    idle_inputs(); #1;
    check(rdat[7:0] === 8'h00 && rdat[31:16] === 16'h0, "R1 reserved bits zero", rdat, {16'h0, m_ctl});
    check(req === 1'b0, "R6 restart ignored with negotiation off", {31'h0, req}, 32'h0);
    cycle();

    // R5: restart, then write with bit9 clear, then start handshake
    idle_inputs(); wr = 1; wd = 32'h0000_1200; cycle();
    idle_inputs(); wr = 1; wd = 32'h0000_1000; cycle();
    idle_inputs(); #1;
    check(req === 1'b1, "R5 restart survives bit9 clear write", {31'h0, req}, 32'h1);
    started = 1; cycle();
    idle_inputs(); #1;
    check(req === 1'b0, "R5 restart cleared by start", {31'h0, req}, 32'h0);
    cycle();

    // R3: soft reset, writes ignored while busy, clear on done
    idle_inputs(); wr = 1; wd = 32'h0000_4D00; cycle();
    idle_inputs(); wr = 1; wd = 32'h0000_8000; cycle();
    idle_inputs(); #1;
    check(pulse === 1'b1, "R3 pulse after soft reset", {31'h0, pulse}, 32'h1);
    check(rdat === 32'h0000_B000, "R3 defaults with busy bit", rdat, 32'h0000_B000);
    wr = 1; wd = 32'h0000_4000; cycle();
    idle_inputs(); #1;
    check(pulse === 1'b0 && lpbk === 1'b0, "R3 one-cycle pulse, write ignored while busy",
          {30'h0, pulse, lpbk}, 32'h0);
    done_i = 1; cycle();
    idle_inputs(); #1;
    check(rdat[15] === 1'b0, "R3 busy clears on done", rdat, 32'h0000_3000);
    cycle();

    // R8 R9: event colliding with a status read is kept
    idle_inputs(); lh = 4'b0001; ll = 4'b0010; cycle();
    idle_inputs(); addr = 1; rd = 1; lh = 4'b0001; ll = 4'b0010; cycle();
    idle_inputs(); addr = 1; #1;
    check(rdat[0] === 1'b1 && rdat[5] === 1'b0, "R8 R9 event kept across read", rdat, 32'h0000_00D1);
    rd = 1; cycle();
    idle_inputs(); addr = 1; #1;
    check(rdat === 32'h0000_00F0, "R8 R9 cleared after read", rdat, 32'h0000_00F0);
    wr = 1; wd = 32'h0000_FFFF; cycle();   // R10: status write ignored

    // random phase
    for (int n = 0; n < 3000; n++) begin
      idle_inputs();
      wr = ($urandom_range(0, 3) == 0);
      rd = ($urandom_range(0, 3) == 0);
      addr = $urandom_range(0, 1);
      wd = $urandom();
      if ($urandom_range(0, 31) != 0) wd[15] = 1'b0;
      done_i = ($urandom_range(0, 3) == 0);
      started = ($urandom_range(0, 5) == 0);
      n_spd = $urandom_range(0, 1);
      n_fdx = $urandom_range(0, 1);
      for (int i = 0; i < NLH; i++) lh[i] = ($urandom_range(0, 7) == 0);
      for (int j = 0; j < NLL; j++) ll[j] = ($urandom_range(0, 7) == 0);
      cycle();
    end
    summary();
  end
endmodule